// File: doc/BRIEF.md
# Dual-Width ALU with Status Flags

This unit performs the arithmetic, logic and shift work of a small accumulator-style processor. Each cycle it takes an operation code, two 8-bit operands and a width-mode bit. The result comes back combinationally in the same cycle, together with a result-write enable. A set of five status flags is loaded at the next rising clock edge: carry, zero, sign, overflow and parity.

When the width-mode bit is 1 the unit works on 4-bit values. Only the low nibble of each operand is used, the upper nibble of the result is forced to zero, and every flag describes 4-bit arithmetic. When the bit is 0 the full byte is used. The compare operation performs a subtraction so that the flags can be loaded, but it never requests a result write. Operand fetch, instruction decode and memory access are outside this block.

Top module: `dualwidth_alu`

## Requirements
- R1: Recognized opcodes are 0x02 add, 0x03 subtract, 0x04 AND, 0x05 OR, 0x06 XOR, 0x07 NOT, 0x0B shift left, 0x0C shift right and 0x0D compare. `writeEn` is 1 only when `opValid` is high and the opcode is a recognized opcode other than compare.
- R2: In 8-bit mode (`narrowMode`=0), add returns (A+B) mod 256. Carry is bit 8 of the sum. Overflow is set when both operands have the same bit 7 and the result's bit 7 differs from it.
- R3: Subtract returns (A-B) modulo the active width. Carry is set as a borrow when the unsigned B is larger than the unsigned A. Overflow is set when the operands differ in their top bit and the result's top bit differs from A's top bit.
- R4: In 4-bit mode (`narrowMode`=1), the upper nibbles of both operands are ignored and `result[7:4]` is 0. Carry comes from bit 4 of the sum or difference, and sign and overflow use bit 3.
- R5: AND, OR, XOR and NOT clear carry and overflow. NOT returns the inverse of the active-width A and ignores B.
- R6: Shift left and shift right move A by the count held in the active-width B. A count equal to or greater than the active width gives 0. Carry is the last bit shifted out, and 0 when the count is 0. Overflow is cleared.
- R7: Zero is set when the active-width result is 0. Sign is the top bit of the active-width result. Parity is set when the active-width result contains an even number of ones.
- R8: The flags are loaded at a rising clock edge only when `opValid` is high and the opcode is recognized. Otherwise they hold their value.
- R9: Compare loads the same flags as subtract on the same operands, and `writeEn` stays 0.
- R10: While `rstN` is low, all five flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; flags load on the rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| opValid | input | 1 | An operation is issued this cycle |
| opCode | input | 8 | Operation select |
| narrowMode | input | 1 | 1 selects 4-bit operation, 0 selects 8-bit |
| srcA | input | DATA_W | First operand (value to shift, minuend) |
| srcB | input | DATA_W | Second operand (addend, subtrahend, shift count) |
| result | output | DATA_W | Combinational result of the current operation |
| writeEn | output | 1 | Result should be written back |
| flagCarry | output | 1 | Registered carry / borrow / last bit shifted out |
| flagZero | output | 1 | Registered zero flag |
| flagSign | output | 1 | Registered sign flag |
| flagOverflow | output | 1 | Registered signed-overflow flag |
| flagParity | output | 1 | Registered even-parity flag |

## Verification
Two things happen in the same cycle. The combinational result and write enable of the operation just issued appear on the outputs, while the flags still show the operation before it. At the next edge the flags are replaced. The bench issues operations back to back, including a compare right after an add and idle or unrecognized opcodes between them. It checks the result and `writeEn` together with the flags that have just been loaded. The expected flags follow a running model that changes only when a recognized operation is issued, so any flag that leaks or goes stale shows up at the port.

// File: rtl/alu_pkg.sv
package alu_pkg;

  localparam logic [7:0] OP_ADD = 8'h02;
  localparam logic [7:0] OP_SUB = 8'h03;
  localparam logic [7:0] OP_AND = 8'h04;
  localparam logic [7:0] OP_OR  = 8'h05;
  localparam logic [7:0] OP_XOR = 8'h06;
  localparam logic [7:0] OP_NOT = 8'h07;
  localparam logic [7:0] OP_SHL = 8'h0B;
  localparam logic [7:0] OP_SHR = 8'h0C;
  localparam logic [7:0] OP_CMP = 8'h0D;

  typedef enum logic [2:0] {
    FN_ADD, FN_SUB, FN_AND, FN_OR, FN_XOR, FN_NOT, FN_SHL, FN_SHR
  } aluFn_e;

  // strobes from control to datapath
  typedef struct packed {
    aluFn_e fn;
    logic   flagLoad;
    logic   resWrite;
  } aluCtrl_t;

  typedef struct packed {
    logic carry;
    logic zero;
    logic sign;
    logic overflow;
    logic parity;
  } aluFlags_t;

endpackage

// File: rtl/alu_ctrl.sv
module alu_ctrl
  import alu_pkg::*;
(
  input  logic       opValid,
  input  logic [7:0] opCode,
  output aluCtrl_t   ctrl
);

  logic known;
  logic isCmp;

  always_comb begin
    known   = 1'b1;
    isCmp   = 1'b0;
    ctrl.fn = FN_ADD;
    case (opCode)
      OP_ADD: ctrl.fn = FN_ADD;
      OP_SUB: ctrl.fn = FN_SUB;
      OP_AND: ctrl.fn = FN_AND;
      OP_OR:  ctrl.fn = FN_OR;
      OP_XOR: ctrl.fn = FN_XOR;
      OP_NOT: ctrl.fn = FN_NOT;
      OP_SHL: ctrl.fn = FN_SHL;
      OP_SHR: ctrl.fn = FN_SHR;
      OP_CMP: begin
        ctrl.fn = FN_SUB;
        isCmp   = 1'b1;
      end
      default: known = 1'b0;
    endcase
    ctrl.flagLoad = opValid && known;
    ctrl.resWrite = opValid && known && !isCmp;
  end

endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  aluCtrl_t          ctrl,
  input  logic              narrowMode,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  output logic [DATA_W-1:0] result,
  output aluFlags_t         flagsQ
);

  localparam int NARROW_W = DATA_W / 2;
  localparam logic [DATA_W-1:0] WIDE_MASK   = {DATA_W{1'b1}};
  localparam logic [DATA_W-1:0] NARROW_MASK = {{(DATA_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

  logic [DATA_W-1:0] mask;
  logic [DATA_W-1:0] opA;
  logic [DATA_W-1:0] opB;
  logic [DATA_W:0]   addX;
  logic [DATA_W:0]   subX;
  logic [DATA_W:0]   shlX;
  logic [DATA_W:0]   shrX;
  logic [DATA_W-1:0] res;
  logic              aTop;
  logic              bTop;
  logic              rTop;
  logic              carryN;
  logic              overN;
  aluFlags_t         flagsN;

  assign mask = narrowMode ? NARROW_MASK : WIDE_MASK;
  assign opA  = srcA & mask;
  assign opB  = srcB & mask;

  // arithmetic and shift candidates, one extra bit for the carry
  assign addX = {1'b0, opA} + {1'b0, opB};
  assign subX = {1'b0, opA} - {1'b0, opB};
  assign shlX = {1'b0, opA} << opB;
  assign shrX = {opA, 1'b0} >> opB;

  always_comb begin
    carryN = 1'b0;
    overN  = 1'b0;
    res    = '0;
    case (ctrl.fn)
      FN_ADD: begin
        res    = addX[DATA_W-1:0];
        carryN = narrowMode ? addX[NARROW_W] : addX[DATA_W];
      end
      FN_SUB: begin
        res    = subX[DATA_W-1:0];
        carryN = narrowMode ? subX[NARROW_W] : subX[DATA_W];
      end
      FN_AND: res = opA & opB;
      FN_OR:  res = opA | opB;
      FN_XOR: res = opA ^ opB;
      FN_NOT: res = ~opA;
      FN_SHL: begin
        res    = shlX[DATA_W-1:0];
        carryN = narrowMode ? shlX[NARROW_W] : shlX[DATA_W];
      end
      FN_SHR: begin
        res    = shrX[DATA_W:1];
        carryN = shrX[0];
      end
      default: res = '0;
    endcase
    res  = res & mask;
    aTop = narrowMode ? opA[NARROW_W-1] : opA[DATA_W-1];
    bTop = narrowMode ? opB[NARROW_W-1] : opB[DATA_W-1];
    rTop = narrowMode ? res[NARROW_W-1] : res[DATA_W-1];
    if (ctrl.fn == FN_ADD) overN = (aTop == bTop) && (rTop != aTop);
    if (ctrl.fn == FN_SUB) overN = (aTop != bTop) && (rTop != aTop);
  end

  always_comb begin
    flagsN.carry    = carryN;
    flagsN.zero     = (res == '0);
    flagsN.sign     = rTop;
    flagsN.overflow = overN;
    flagsN.parity   = ~^res;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flagsQ <= '0;
    else if (ctrl.flagLoad) flagsQ <= flagsN;
  end

  assign result = res;

endmodule

// File: rtl/dualwidth_alu.sv
module dualwidth_alu
  import alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [7:0]        opCode,
  input  logic              narrowMode,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  output logic [DATA_W-1:0] result,
  output logic              writeEn,
  output logic              flagCarry,
  output logic              flagZero,
  output logic              flagSign,
  output logic              flagOverflow,
  output logic              flagParity
);

  aluCtrl_t  ctrl;
  aluFlags_t flagsQ;

  alu_ctrl u_ctrl (
    .opValid (opValid),
    .opCode  (opCode),
    .ctrl    (ctrl)
  );

  alu_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctrl       (ctrl),
    .narrowMode (narrowMode),
    .srcA       (srcA),
    .srcB       (srcB),
    .result     (result),
    .flagsQ     (flagsQ)
  );

  assign writeEn      = ctrl.resWrite;
  assign flagCarry    = flagsQ.carry;
  assign flagZero     = flagsQ.zero;
  assign flagSign     = flagsQ.sign;
  assign flagOverflow = flagsQ.overflow;
  assign flagParity   = flagsQ.parity;

endmodule

// File: rtl/dualwidth_alu_chk.sv
module dualwidth_alu_chk
  import alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              opValid,
  input logic [7:0]        opCode,
  input logic              narrowMode,
  input logic [DATA_W-1:0] result,
  input logic              writeEn,
  input logic              flagCarry,
  input logic              flagZero,
  input logic              flagSign,
  input logic              flagOverflow,
  input logic              flagParity
);

  localparam int NARROW_W = DATA_W / 2;

  logic known;
  logic isLogic;
  assign isLogic = (opCode == OP_AND) || (opCode == OP_OR) ||
                   (opCode == OP_XOR) || (opCode == OP_NOT);
  assign known = isLogic || (opCode == OP_ADD) || (opCode == OP_SUB) ||
                 (opCode == OP_SHL) || (opCode == OP_SHR) || (opCode == OP_CMP);

  // R1: no write without an issued operation
  a_r1_idle_no_write: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |-> !writeEn);

  // R9: compare never writes
  a_r9_cmp_no_write: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == OP_CMP) |-> !writeEn);

  // R4: narrow result upper nibble is zero
  a_r4_narrow_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    narrowMode |-> (result[DATA_W-1:NARROW_W] == '0));

  // R5: logic ops clear carry and overflow
  a_r5_logic_clears: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && isLogic) |=> (!flagCarry && !flagOverflow));

  // R7: zero flag follows the result that was presented
  a_r7_zero_matches: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && known) |=> (flagZero == ($past(result) == '0)));

  // R8: flags hold when nothing is issued
  a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rstN)
    !(opValid && known) |=>
      $stable({flagCarry, flagZero, flagSign, flagOverflow, flagParity}));

  // R10: reset clears flags
  a_r10_reset_clear: assert property (@(posedge clk)
    !rstN |-> ({flagCarry, flagZero, flagSign, flagOverflow, flagParity} == 5'b0));

endmodule

bind dualwidth_alu dualwidth_alu_chk #(.DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .opValid      (opValid),
  .opCode       (opCode),
  .narrowMode   (narrowMode),
  .result       (result),
  .writeEn      (writeEn),
  .flagCarry    (flagCarry),
  .flagZero     (flagZero),
  .flagSign     (flagSign),
  .flagOverflow (flagOverflow),
  .flagParity   (flagParity)
);

// File: tb/dualwidth_alu_tb.sv
module dualwidth_alu_tb;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       opValid = 1'b0;
  logic [7:0] opCode = 8'h00;
  logic       narrowMode = 1'b0;
  logic [7:0] srcA = 8'h00;
  logic [7:0] srcB = 8'h00;
  logic [7:0] result;
  logic       writeEn;
  logic       flagCarry, flagZero, flagSign, flagOverflow, flagParity;

  always #(CLK_PERIOD/2) clk = ~clk;

  dualwidth_alu u_dut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode),
    .narrowMode(narrowMode), .srcA(srcA), .srcB(srcB), .result(result),
    .writeEn(writeEn), .flagCarry(flagCarry), .flagZero(flagZero),
    .flagSign(flagSign), .flagOverflow(flagOverflow), .flagParity(flagParity)
  );

  typedef struct {
    string      tag;
    bit         chkRes;
    logic [7:0] res;
    logic       we;
    logic [4:0] flags; // carry, zero, sign, overflow, parity
  } item_t;

  item_t      sbq[$];
  int         nRun = 0;
  int         nFail = 0;
  logic [4:0] expFlags = 5'b0;
  bit         driveDone = 1'b0;

  task automatic check(string tag, string what, int act, int exp);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // independent reference: bit-serial shifts, integer arithmetic
  task automatic model(input logic [7:0] op, input bit nm, input int a, input int b,
                       output int r, output bit c, output bit v, output bit known);
    int w, msk, aa, bb, s;
    w = nm ? 4 : 8;
    msk = (1 << w) - 1;
    aa = a & msk;
    bb = b & msk;
    c = 0; v = 0; r = 0; known = 1;
    case (op)
      8'h02: begin
        s = aa + bb; r = s & msk; c = ((s >> w) & 1) != 0;
        v = (((aa >> (w-1)) & 1) == ((bb >> (w-1)) & 1)) &&
            (((r >> (w-1)) & 1) != ((aa >> (w-1)) & 1));
      end
      8'h03, 8'h0D: begin
        s = aa - bb; r = s & msk; c = bb > aa;
        v = (((aa >> (w-1)) & 1) != ((bb >> (w-1)) & 1)) &&
            (((r >> (w-1)) & 1) != ((aa >> (w-1)) & 1));
      end
      8'h04: r = aa & bb;
      8'h05: r = aa | bb;
      8'h06: r = aa ^ bb;
      8'h07: r = (~aa) & msk;
      8'h0B: begin
        r = aa;
        for (int i = 0; i < bb; i++) begin
          c = ((r >> (w-1)) & 1) != 0;
          r = (r << 1) & msk;
        end
      end
      8'h0C: begin
        r = aa;
        for (int i = 0; i < bb; i++) begin
          c = (r & 1) != 0;
          r = r >> 1;
        end
      end
      default: known = 0;
    endcase
  endtask

  task automatic issue(string tag, bit valid, logic [7:0] op, bit nm, int a, int b);
    item_t it;
    int r; bit c, v, known, par;
    @(negedge clk);
    opValid = valid; opCode = op; narrowMode = nm;
    srcA = a[7:0]; srcB = b[7:0];
    model(op, nm, a, b, r, c, v, known);
    par = 1;
    for (int i = 0; i < 8; i++) if ((r >> i) & 1) par = !par;
    if (valid && known)
      expFlags = {c, r == 0, ((r >> (nm ? 3 : 7)) & 1) != 0, v, par};
    it.tag = tag;
    it.chkRes = valid && known;
    it.res = r[7:0];
    it.we = valid && known && (op != 8'h0D);
    it.flags = expFlags;
    sbq.push_back(it);
  endtask

  // monitor: sample one step after the edge; inputs stay until the next negedge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sbq.size() > 0) begin
        item_t it;
        it = sbq.pop_front();
        if (it.chkRes) check(it.tag, "result", result, it.res);
        check(it.tag, "writeEn", writeEn, it.we);
        check(it.tag, "flags", {flagCarry, flagZero, flagSign, flagOverflow, flagParity},
              it.flags);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10", "flags in reset",
          {flagCarry, flagZero, flagSign, flagOverflow, flagParity}, 0);
    rstN = 1'b1;

    // R2: 8-bit add
    issue("R2 add ovf",   1, 8'h02, 0, 8'h7F, 8'h01);
    issue("R2 add carry", 1, 8'h02, 0, 8'hFF, 8'h01);
    // R9: compare right after an add
    issue("R9 cmp eq",    1, 8'h0D, 0, 8'h42, 8'h42);
    issue("R9 cmp lt",    1, 8'h0D, 0, 8'h10, 8'h20);
    // R3: subtract
    issue("R3 sub borrow", 1, 8'h03, 0, 8'h10, 8'h20);
    issue("R3 sub ovf",    1, 8'h03, 0, 8'h80, 8'h01);
    // R4: narrow arithmetic, upper nibbles ignored
    issue("R4 add narrow", 1, 8'h02, 1, 8'hA9, 8'h58);
    issue("R4 sub narrow", 1, 8'h03, 1, 8'h13, 8'hF5);
    issue("R4 cmp narrow", 1, 8'h0D, 1, 8'hF7, 8'h07);
    // R5: logic ops
    issue("R5 and", 1, 8'h04, 0, 8'hF0, 8'h3C);
    issue("R5 or",  1, 8'h05, 0, 8'h81, 8'h18);
    issue("R5 xor", 1, 8'h06, 0, 8'hAA, 8'hAA);
    issue("R5 not narrow", 1, 8'h07, 1, 8'h3C, 8'hFF);
    issue("R5 not wide",   1, 8'h07, 0, 8'h0F, 8'h55);
    // R6: shifts and counts at the width boundary
    issue("R6 shl 0", 1, 8'h0B, 0, 8'h81, 0);
    issue("R6 shl 1", 1, 8'h0B, 0, 8'h81, 1);
    issue("R6 shl 8", 1, 8'h0B, 0, 8'h01, 8);
    issue("R6 shl 9", 1, 8'h0B, 0, 8'hFF, 9);
    issue("R6 shr 3", 1, 8'h0C, 0, 8'hB4, 3);
    issue("R6 shr narrow 4", 1, 8'h0C, 1, 8'hF9, 8'h04);
    issue("R6 shr narrow 2", 1, 8'h0C, 1, 8'hF6, 8'h22);
    issue("R6 shl narrow 5", 1, 8'h0B, 1, 8'h0F, 8'h05);
    // R7: zero, sign, parity variety
    issue("R7 sub zero",  1, 8'h03, 0, 8'h37, 8'h37);
    issue("R7 add odd",   1, 8'h02, 0, 8'h01, 8'h00);
    // R8 / R1: idle and unrecognized opcodes leave flags, no write
    issue("R8 idle add",  0, 8'h02, 0, 8'hFF, 8'h01);
    issue("R1 unknown",   1, 8'h01, 0, 8'h00, 8'h00);
    issue("R1 halt code", 1, 8'hFF, 0, 8'h80, 8'h80);
    issue("R8 idle cmp",  0, 8'h0D, 1, 8'h00, 8'h00);
    // mixed pattern sweep
    for (int k = 0; k < 60; k++) begin
      logic [7:0] op;
      case (k % 9)
        0: op = 8'h02; 1: op = 8'h03; 2: op = 8'h04;
        3: op = 8'h05; 4: op = 8'h06; 5: op = 8'h07;
        6: op = 8'h0B; 7: op = 8'h0C; default: op = 8'h0D;
      endcase
      issue("R1 sweep", 1, op, (k % 2) == 1, (k * 73 + 19) & 255,
            (op == 8'h0B || op == 8'h0C) ? (k % 11) : ((k * 151 + 7) & 255));
    end
    @(negedge clk);
    opValid = 1'b0;
    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule